// File: doc/BRIEF.md
# Soft-Start and Fault Sequencer

This block governs when the four-switch PWM stage may drive, and how the loop's command is limited while the stage is brought up or taken down. It holds a digital soft-start level that climbs by a small step at a fixed cadence and falls by a step ten times larger. The analog comparators sit outside the block. It sees only their digital results: two supply flags that form an undervoltage lockout with hysteresis, a reference-good flag, an external disable request, a peak-current flag and an overcurrent flag.

A lost supply or a bad reference is a hard fault. The block drops the enable at once and clears the level. An external disable does the same, but it ranks below a hard fault. An overcurrent while the stage is starting or running also drops the enable at once, then lowers the level at the fast rate. When the level falls below the stop threshold, the block starts a fresh soft-start without outside help. The enable returns only once the level climbs back above that threshold.

The error code from the loop arrives on a valid/ready stream and leaves on a second stream, limited to the current level. The block stores nothing on this path. Valid passes forward and ready passes backward in the same cycle, so back-pressure reaches the source unchanged, and the source must hold its code while it is stalled. A rising peak-current flag produces a one-cycle pulse that ends the present PWM cycle.

Top module: `ssq_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `ss_level_o` is 0, `out_en_o` is 0 and `cyc_term_o` is 0.
- R2: The supply counts as good once `vdd_above_on_i` is 1. It stays good while `vdd_above_off_i` is 1, even after `vdd_above_on_i` returns to 0. After `vdd_above_off_i` drops, the supply needs `vdd_above_on_i` again before a restart.
- R3: A bad supply or `ref_ok_i` = 0 drives `out_en_o` low in the same cycle. It makes `ss_level_o` 0 at the next clock edge and holds it there until the fault clears.
- R4: `dis_req_i` = 1 drives `out_en_o` low in the same cycle and makes `ss_level_o` 0 at the next edge. After release, the level climbs again from 0.
- R5: Priority runs hard fault, then disable, then overcurrent. `oc_flt_i` has no effect while disabled or locked out, and the level stays 0.
- R6: In soft-start, the level rises by UP_STEP once every RATE_DIV cycles and saturates at 2^LVL_W-1. The sequencer then enters run.
- R7: `out_en_o` is 1 only with no fault present and either in run, or in soft-start with `ss_level_o` > STOP_THR.
- R8: `oc_flt_i` in soft-start or run drives `out_en_o` low in the same cycle. It starts a soft-stop in which the level falls by DN_MULT*UP_STEP every RATE_DIV cycles, saturating at 0.
- R9: Once the soft-stop level is below STOP_THR, the level climbs again at the soft-start rate. The outputs come back above STOP_THR, and run follows at full level.
- R10: `clp_code_o` equals the smaller of `err_code_i` and `ss_level_o`, so a code passes unchanged in run.
- R11: `clp_valid_o` equals `err_valid_i` and `err_ready_o` equals `clp_ready_i` in the same cycle, with no storage.
- R12: `cyc_term_o` is a one-cycle pulse on each 0-to-1 change of `pk_cur_i`. Holding the flag high gives only one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vdd_above_on_i | input | 1 | Supply above the start threshold |
| vdd_above_off_i | input | 1 | Supply above the minimum operating threshold |
| ref_ok_i | input | 1 | Reference voltage good |
| dis_req_i | input | 1 | External disable request |
| pk_cur_i | input | 1 | Peak-current comparator result |
| oc_flt_i | input | 1 | Overcurrent comparator result |
| err_valid_i | input | 1 | Error code valid |
| err_ready_o | output | 1 | Error code accepted |
| err_code_i | input | LVL_W | Error code from the loop |
| clp_valid_o | output | 1 | Limited code valid |
| clp_ready_i | input | 1 | Downstream ready |
| clp_code_o | output | LVL_W | Error code limited to the soft-start level |
| out_en_o | output | 1 | PWM output enable |
| cyc_term_o | output | 1 | Cycle-terminate pulse |
| ss_level_o | output | LVL_W | Present soft-start level (clamp value) |

## Verification
The assertions check several rules on every cycle. Each fault kind holds the enable low, and a disable or bad reference leaves the level at zero one edge later. The enable never shows while the level is at or below the threshold. Every rise of the level is one up-step or a jump to full scale, and every fall is one down-step or a drop to zero. The clamp bound always holds, and the terminate pulse never lasts two cycles. Only the bench scenarios can show the rest:
- the exact ramp rates over a window,
- the automatic restart after a soft-stop and the lowest level it reaches,
- the hysteresis of the supply flags,
- priority when faults overlap,
- back-pressure passing through.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  typedef enum logic [2:0] {
    SQ_LOCKOUT  = 3'd0,
    SQ_DISABLED = 3'd1,
    SQ_START    = 3'd2,
    SQ_RUN      = 3'd3,
    SQ_STOP     = 3'd4
  } seq_state_e;
endpackage

// File: rtl/ssq_supply_hyst.sv
module ssq_supply_hyst (
  input  logic clk,
  input  logic rst_n,
  input  logic above_on_i,
  input  logic above_off_i,
  output logic supply_ok_o
);
  logic good_q;

  // Once good, only the lower threshold matters; otherwise the upper one.
  assign supply_ok_o = good_q ? above_off_i : above_on_i;

  always_ff @(posedge clk) begin
    if (!rst_n) good_q <= 1'b0;
    else        good_q <= supply_ok_o;
  end
endmodule

// File: rtl/ssq_ramp.sv
module ssq_ramp #(
  parameter int LVL_W    = 10,
  parameter int UP_STEP  = 4,
  parameter int DN_MULT  = 10,
  parameter int RATE_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             restart_i,
  output logic [LVL_W-1:0] lvl_o
);
  localparam int DIV_W = (RATE_DIV > 2) ? $clog2(RATE_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(RATE_DIV - 1);
  localparam logic [LVL_W:0]   UP_X  = (LVL_W + 1)'(UP_STEP);
  localparam logic [LVL_W:0]   DN_X  = (LVL_W + 1)'(UP_STEP * DN_MULT);
  localparam logic [LVL_W:0]   MAX_X = {1'b0, {LVL_W{1'b1}}};

  logic [DIV_W-1:0] div_q;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [LVL_W:0]   ext, sum, dif;
  logic             moving, tick;

  assign moving = up_i | dn_i;
  assign tick   = moving && (div_q == DIV_LAST);
  assign ext    = {1'b0, lvl_q};
  assign sum    = ext + UP_X;
  assign dif    = ext - DN_X;

  always_comb begin
    lvl_d = lvl_q;
    if (clr_i)
      lvl_d = '0;
    else if (tick && up_i)
      lvl_d = (sum > MAX_X) ? {LVL_W{1'b1}} : sum[LVL_W-1:0];
    else if (tick && dn_i)
      lvl_d = (ext < DN_X) ? '0 : dif[LVL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      lvl_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      if (restart_i || !moving || tick) div_q <= '0;
      else                              div_q <= div_q + 1'b1;
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/ssq_ctrl.sv
module ssq_ctrl
  import ssq_pkg::*;
#(
  parameter int LVL_W    = 10,
  parameter int STOP_THR = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok_i,
  input  logic             ref_ok_i,
  input  logic             dis_i,
  input  logic             oc_i,
  input  logic [LVL_W-1:0] lvl_i,
  output seq_state_e       state_o,
  output seq_state_e       state_nxt_o,
  output logic             out_en_o
);
  localparam logic [LVL_W-1:0] THR = LVL_W'(STOP_THR);
  localparam logic [LVL_W-1:0] FULL = {LVL_W{1'b1}};

  seq_state_e state_q, state_d;
  logic       hard;

  assign hard = !supply_ok_i || !ref_ok_i;

  always_comb begin
    state_d = state_q;
    if (hard)       state_d = SQ_LOCKOUT;
    else if (dis_i) state_d = SQ_DISABLED;
    else begin
      case (state_q)
        SQ_LOCKOUT, SQ_DISABLED: state_d = SQ_START;
        SQ_START: begin
          if (oc_i)              state_d = SQ_STOP;
          else if (lvl_i == FULL) state_d = SQ_RUN;
        end
        SQ_RUN:  if (oc_i)        state_d = SQ_STOP;
        SQ_STOP: if (lvl_i < THR) state_d = SQ_START;
        default: state_d = SQ_LOCKOUT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SQ_LOCKOUT;
    else        state_q <= state_d;
  end

  // Fault terms gate the enable combinationally: no cycle of exposure.
  assign out_en_o = !hard && !dis_i && !oc_i &&
                    ((state_q == SQ_RUN) || ((state_q == SQ_START) && (lvl_i > THR)));
  assign state_o     = state_q;
  assign state_nxt_o = state_d;
endmodule

// File: rtl/ssq_term_pulse.sv
module ssq_term_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_i,
  output logic pulse_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= flag_i;
  end

  assign pulse_o = flag_i && !prev_q;
endmodule

// File: rtl/ssq_sequencer.sv
module ssq_sequencer
  import ssq_pkg::*;
#(
  parameter int LVL_W    = 10,
  parameter int UP_STEP  = 4,
  parameter int DN_MULT  = 10,
  parameter int RATE_DIV = 4,
  parameter int STOP_THR = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vdd_above_on_i,
  input  logic             vdd_above_off_i,
  input  logic             ref_ok_i,
  input  logic             dis_req_i,
  input  logic             pk_cur_i,
  input  logic             oc_flt_i,
  input  logic             err_valid_i,
  output logic             err_ready_o,
  input  logic [LVL_W-1:0] err_code_i,
  output logic             clp_valid_o,
  input  logic             clp_ready_i,
  output logic [LVL_W-1:0] clp_code_o,
  output logic             out_en_o,
  output logic             cyc_term_o,
  output logic [LVL_W-1:0] ss_level_o
);
  logic             supply_ok;
  seq_state_e       state_q, state_d;
  logic [LVL_W-1:0] lvl;
  logic             clr, up, dn, restart;

  ssq_supply_hyst u_hyst (
    .clk(clk), .rst_n(rst_n),
    .above_on_i(vdd_above_on_i), .above_off_i(vdd_above_off_i),
    .supply_ok_o(supply_ok)
  );

  ssq_ctrl #(.LVL_W(LVL_W), .STOP_THR(STOP_THR)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .supply_ok_i(supply_ok), .ref_ok_i(ref_ok_i),
    .dis_i(dis_req_i), .oc_i(oc_flt_i), .lvl_i(lvl),
    .state_o(state_q), .state_nxt_o(state_d), .out_en_o(out_en_o)
  );

  // Clearing follows the next state so a fault empties the level at the next edge.
  assign clr     = (state_d == SQ_LOCKOUT) || (state_d == SQ_DISABLED);
  assign up      = (state_q == SQ_START);
  assign dn      = (state_q == SQ_STOP);
  assign restart = (state_d != state_q);

  ssq_ramp #(
    .LVL_W(LVL_W), .UP_STEP(UP_STEP), .DN_MULT(DN_MULT), .RATE_DIV(RATE_DIV)
  ) u_ramp (
    .clk(clk), .rst_n(rst_n),
    .clr_i(clr), .up_i(up), .dn_i(dn), .restart_i(restart),
    .lvl_o(lvl)
  );

  ssq_term_pulse u_term (
    .clk(clk), .rst_n(rst_n), .flag_i(pk_cur_i), .pulse_o(cyc_term_o)
  );

  assign clp_valid_o = err_valid_i;
  assign err_ready_o = clp_ready_i;
  assign clp_code_o  = (err_code_i < lvl) ? err_code_i : lvl;
  assign ss_level_o  = lvl;
endmodule

// File: rtl/ssq_checker.sv
module ssq_checker #(
  parameter int LVL_W    = 10,
  parameter int UP_STEP  = 4,
  parameter int DN_MULT  = 10,
  parameter int STOP_THR = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_ok_i,
  input logic             dis_req_i,
  input logic             pk_cur_i,
  input logic             oc_flt_i,
  input logic [LVL_W-1:0] err_code_i,
  input logic [LVL_W-1:0] clp_code_o,
  input logic             out_en_o,
  input logic             cyc_term_o,
  input logic [LVL_W-1:0] ss_level_o
);
  localparam logic [LVL_W-1:0] C_UP   = LVL_W'(UP_STEP);
  localparam logic [LVL_W-1:0] C_DN   = LVL_W'(UP_STEP * DN_MULT);
  localparam logic [LVL_W-1:0] C_THR  = LVL_W'(STOP_THR);
  localparam logic [LVL_W-1:0] C_FULL = {LVL_W{1'b1}};

  AST_REF_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_ok_i |-> !out_en_o); // R3
  AST_REF_CLEARS_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_ok_i |=> (ss_level_o == '0)); // R3
  AST_DIS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    dis_req_i |-> !out_en_o); // R4
  AST_DIS_CLEARS_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    dis_req_i |=> (ss_level_o == '0)); // R4
  AST_EN_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_o |-> (ss_level_o > C_THR)); // R7
  AST_RISE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_level_o > $past(ss_level_o)) |->
      ((ss_level_o - $past(ss_level_o) == C_UP) || (ss_level_o == C_FULL))); // R6
  AST_OC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    oc_flt_i |-> !out_en_o); // R8
  AST_FALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_level_o < $past(ss_level_o)) |->
      ((ss_level_o == '0) || ($past(ss_level_o) - ss_level_o == C_DN))); // R8
  AST_CLAMP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (clp_code_o <= ss_level_o) && (clp_code_o <= err_code_i)); // R10
  AST_TERM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_term_o |=> !cyc_term_o); // R12
  AST_TERM_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_term_o |-> pk_cur_i); // R12
endmodule

bind ssq_sequencer ssq_checker #(
  .LVL_W(LVL_W), .UP_STEP(UP_STEP), .DN_MULT(DN_MULT), .STOP_THR(STOP_THR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_ok_i(ref_ok_i), .dis_req_i(dis_req_i),
  .pk_cur_i(pk_cur_i), .oc_flt_i(oc_flt_i), .err_code_i(err_code_i),
  .clp_code_o(clp_code_o), .out_en_o(out_en_o), .cyc_term_o(cyc_term_o),
  .ss_level_o(ss_level_o)
);

// File: tb/test_ssq_sequencer.sv
module test_ssq_sequencer;
  localparam int LW = 10, UP = 4, DNM = 10, DIV = 4, THR = 128;
  localparam int FULL = (1 << LW) - 1;
  localparam int DN = UP * DNM;

  logic clk = 1'b0, rst_n = 1'b0;
  logic above_on = 1'b1, above_off = 1'b1, ref_ok = 1'b1, dis = 1'b0;
  logic pk = 1'b0, oc = 1'b0, evalid = 1'b0, cready = 1'b0;
  logic [LW-1:0] ecode = '0;
  logic eready, cvalid, out_en, term;
  logic [LW-1:0] ccode, lvl;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ssq_sequencer #(.LVL_W(LW), .UP_STEP(UP), .DN_MULT(DNM), .RATE_DIV(DIV), .STOP_THR(THR))
  i_ssq_sequencer (
    .clk(clk), .rst_n(rst_n), .vdd_above_on_i(above_on), .vdd_above_off_i(above_off),
    .ref_ok_i(ref_ok), .dis_req_i(dis), .pk_cur_i(pk), .oc_flt_i(oc),
    .err_valid_i(evalid), .err_ready_o(eready), .err_code_i(ecode),
    .clp_valid_o(cvalid), .clp_ready_i(cready), .clp_code_o(ccode),
    .out_en_o(out_en), .cyc_term_o(term), .ss_level_o(lvl)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_full(input string req);
    int n = 0;
    while (lvl != LW'(FULL) && n < 5000) begin cyc(1); n++; end
    chk(lvl == LW'(FULL), req, int'(lvl), FULL);
  endtask

  task automatic t_reset;
    cyc(3);
    chk(lvl == 0 && out_en == 0 && term == 0, "R1 reset", int'(lvl) + int'(out_en), 0);
    rst_n = 1'b1;
    cyc(1);
    chk(lvl == 0 && out_en == 0, "R1 first cycle", int'(lvl), 0);
  endtask

  task automatic t_startup;
    int a, b, errs;
    errs = 0;
    evalid = 1'b1; cready = 1'b1; ecode = LW'(1000);
    cyc(20);
    #1;
    chk(ccode == lvl, "R10 clamp in ramp", int'(ccode), int'(lvl));
    chk(cvalid == 1 && eready == 1, "R11 pass", int'(cvalid) + int'(eready), 2);
    cready = 1'b0; evalid = 1'b0;
    #1;
    chk(eready == 0 && cvalid == 0, "R11 backpressure", int'(eready) + int'(cvalid), 0);
    cready = 1'b1; evalid = 1'b1;
    a = int'(lvl);
    for (int i = 0; i < 40; i++) begin
      cyc(1);
      if (out_en != (int'(lvl) > THR)) errs++;
    end
    b = int'(lvl);
    chk(b - a == 10 * UP, "R6 up rate", b - a, 10 * UP);
    while (lvl != LW'(FULL) && errs < 100 && b < 100000) begin
      cyc(1); b++;
      if (lvl != LW'(FULL) && out_en != (int'(lvl) > THR)) errs++;
    end
    chk(errs == 0, "R7 enable vs threshold", errs, 0);
    wait_full("R6 reaches full");
    cyc(1);
    #1;
    chk(out_en == 1, "R6 run enabled", int'(out_en), 1);
    chk(ccode == LW'(1000), "R10 pass in run", int'(ccode), 1000);
  endtask

  task automatic t_softstop;
    int a, b, mn, expmin;
    oc = 1'b1;
    #1;
    chk(out_en == 0, "R8 immediate off", int'(out_en), 0);
    cyc(1);
    oc = 1'b0;
    a = int'(lvl);
    cyc(20);
    b = int'(lvl);
    chk(a - b == 5 * DN, "R8 down rate", a - b, 5 * DN);
    chk(out_en == 0, "R8 off in stop", int'(out_en), 0);
    expmin = FULL;
    while (expmin >= THR) expmin = (expmin >= DN) ? expmin - DN : 0;
    mn = int'(lvl);
    for (int i = 0; i < 400 && out_en == 0; i++) begin
      cyc(1);
      if (int'(lvl) < mn) mn = int'(lvl);
    end
    chk(mn == expmin, "R9 restart level", mn, expmin);
    chk(out_en == 1 && int'(lvl) > THR, "R9 re-enable", int'(lvl), THR + 1);
    wait_full("R9 back to run");
  endtask

  task automatic t_disable;
    dis = 1'b1;
    #1;
    chk(out_en == 0, "R4 immediate off", int'(out_en), 0);
    cyc(1);
    chk(lvl == 0, "R4 level cleared", int'(lvl), 0);
    oc = 1'b1;
    cyc(12);
    chk(lvl == 0 && out_en == 0, "R5 oc ignored while disabled", int'(lvl), 0);
    oc = 1'b0; dis = 1'b0;
    cyc(1);
    cyc(2 * DIV);
    chk(lvl == LW'(2 * UP), "R4 restart from zero", int'(lvl), 2 * UP);
    wait_full("R4 back to run");
  endtask

  task automatic t_priority;
    dis = 1'b1; oc = 1'b1;
    cyc(1);
    chk(lvl == 0, "R5 disable beats oc", int'(lvl), 0);
    oc = 1'b0; ref_ok = 1'b0;
    cyc(1);
    dis = 1'b0;
    cyc(10);
    chk(lvl == 0 && out_en == 0, "R5 hard fault beats release", int'(lvl), 0);
    ref_ok = 1'b1;
    cyc(20);
    chk(lvl > 0, "R3 restart after ref", int'(lvl), 1);
    wait_full("R3 back to run");
  endtask

  task automatic t_ref;
    ref_ok = 1'b0;
    #1;
    chk(out_en == 0, "R3 immediate off", int'(out_en), 0);
    cyc(1);
    chk(lvl == 0, "R3 level cleared", int'(lvl), 0);
    ref_ok = 1'b1;
    cyc(1);
    wait_full("R3 run again");
  endtask

  task automatic t_hyst;
    above_on = 1'b0;
    cyc(30);
    chk(out_en == 1 && lvl == LW'(FULL), "R2 holds above off", int'(out_en), 1);
    above_off = 1'b0;
    #1;
    chk(out_en == 0, "R2 off below min", int'(out_en), 0);
    cyc(1);
    chk(lvl == 0, "R2 level cleared", int'(lvl), 0);
    above_off = 1'b1;
    cyc(30);
    chk(lvl == 0 && out_en == 0, "R2 needs start threshold", int'(lvl), 0);
    above_on = 1'b1;
    cyc(30);
    chk(lvl > 0, "R2 restart", int'(lvl), 1);
    wait_full("R2 back to run");
  endtask

  task automatic t_term;
    pk = 1'b1;
    #1;
    chk(term == 1, "R12 pulse on rise", int'(term), 1);
    cyc(1);
    chk(term == 0, "R12 single cycle", int'(term), 0);
    cyc(5);
    chk(term == 0, "R12 held flag", int'(term), 0);
    pk = 1'b0;
    cyc(2);
    pk = 1'b1;
    #1;
    chk(term == 1, "R12 second rise", int'(term), 1);
    pk = 1'b0;
  endtask

  initial begin
    int n = 0;
    while (!done && n < 150000) begin @(posedge clk); n++; end
    if (!done) begin
      chk(1'b0, "watchdog", n, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_startup();
    t_softstop();
    t_disable();
    t_priority();
    t_ref();
    t_hyst();
    t_term();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule